// File: doc/BRIEF.md
# Parallel EPROM Mode Decoder Model

A synthesizable behavioural model of the control side of a word-wide ultraviolet-erasable EPROM. Each cycle it decodes an active-low chip-enable/program strobe, an active-low output-enable, two digital flags (one for a raised programming supply, one for an overvoltage on address line 9) and address bit 0. From these it picks one of seven operating modes: read, output off, standby, program, program verify, program inhibit and identifier readout. It drives a 16-bit data bus together with a separate enable for an external tri-state buffer.

The storage is a small array whose size is set by a parameter. A program pulse captures address and data while it is active. It commits the word when the strobe returns high, and the commit can only clear bits. An erase input returns the whole array to all ones. In identifier mode the bus carries fixed manufacturer or device codes that carry odd parity. The model is meant to stand in for the memory in a system-level design or to back a programmer's control sequencer.

Top module: `eprom_mode_model`

## Requirements
- R1: With ce_ni=0, oe_ni=0 and a9_hv_i=0, data_oe_o is 1 and data_o equals the word stored at addr_i. This holds whatever the value of vpp_hi_i.
- R2: With ce_ni=0, oe_ni=1 and vpp_hi_i=0, data_oe_o is 0.
- R3: With ce_ni=1 and vpp_hi_i=0, data_oe_o is 0 whatever oe_ni and the other inputs are. This also holds while reset is asserted.
- R4: With vpp_hi_i=1, ce_ni=0 and oe_ni=1 (program), data_oe_o is 0. addr_i and data_i are captured at every clock in this mode. At the first clock edge where ce_ni is sampled 1 after one or more program cycles, the last captured word is committed. Its new value is visible on reads from the cycle after that edge.
- R5: A program pulse that ends with ce_ni still low commits nothing. One cut short by rst_ni=0 also commits nothing.
- R6: With vpp_hi_i=1, ce_ni=1 and oe_ni=0 (verify), data_oe_o is 1 and data_o equals the word stored at addr_i.
- R7: With vpp_hi_i=1, ce_ni=1 and oe_ni=1 (inhibit), data_oe_o is 0 and no word is written, whatever data_i is.
- R8: With ce_ni=0, oe_ni=0 and a9_hv_i=1, data_oe_o is 1. data_o is 16'h0001 when addr_i[0]=0 and 16'h0019 when addr_i[0]=1. Bits 15:8 read zero, and bit 7 is set so that bits 7:0 hold an odd number of ones. This holds whatever the value of vpp_hi_i.
- R9: A commit stores the old word AND data_i, so a bit can only go from 1 to 0.
- R10: erase_i sampled 1 at a clock edge sets every word to 16'hFFFF after that edge. It takes priority over a commit at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the control state |
| ce_ni | input | 1 | Active-low chip enable / program strobe |
| oe_ni | input | 1 | Active-low output enable |
| vpp_hi_i | input | 1 | Programming supply raised |
| a9_hv_i | input | 1 | Overvoltage present on address line 9 |
| erase_i | input | 1 | Set the whole array to ones |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Data to program |
| data_o | output | DATA_W | Data driven onto the bus |
| data_oe_o | output | 1 | Bus driver enable |

## Verification
The commit of a program pulse and the program-verify read can fall in the same cycle. Raising ce_ni with oe_ni low moves the block from program directly into verify. In that cycle the bus must still show the old word, because the commit edge has not yet occurred. From the next cycle the bus must show the old word ANDed with the programmed data. The bench provokes this on every address in two programming passes that use different arithmetic patterns. It samples in both cycles and compares against its own array model. A separate case puts erase and a commit on the same edge and expects all ones.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_READ,
    MD_OUT_OFF,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT,
    MD_IDENT
  } mode_e;

  localparam int unsigned IdW = 8;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  vpp_hi_i,
  input  logic  a9_hv_i,
  output mode_e mode_o,
  output logic  drive_o
);
  always_comb begin
    if (!ce_ni) begin
      if (!oe_ni) mode_o = a9_hv_i ? MD_IDENT : MD_READ;
      else        mode_o = vpp_hi_i ? MD_PROG : MD_OUT_OFF;
    end else begin
      if (vpp_hi_i) mode_o = oe_ni ? MD_INHIBIT : MD_VERIFY;
      else          mode_o = MD_STANDBY;
    end
  end

  always_comb begin
    unique case (mode_o)
      MD_READ, MD_VERIFY, MD_IDENT: drive_o = 1'b1;
      default:                      drive_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              ce_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      pulse_q <= (mode_i == MD_PROG);
      if (mode_i == MD_PROG) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end
  end

  // pulse ends on strobe rising; any other exit drops it
  assign wr_en_o = pulse_q & ce_ni;
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (erase_i) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_and_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !erase_i) |=>
      ((mem_q[$past(wr_addr_i)] & ~$past(mem_q[wr_addr_i])) == '0));

  assert_erase_ones_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (rd_data_o == '1));
endmodule

// File: rtl/eprom_ident.sv
module eprom_ident
  import eprom_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter logic [6:0]  MFR_ID7 = 7'h01,
  parameter logic [6:0]  DEV_ID7 = 7'h19
) (
  input  logic              sel_dev_i,
  output logic [DATA_W-1:0] code_o
);
  logic [6:0]     body;
  logic [IdW-1:0] byte_w;

  assign body   = sel_dev_i ? DEV_ID7 : MFR_ID7;
  assign byte_w = {~^body, body};

  generate
    if (DATA_W > IdW) begin : g_wide
      assign code_o = {{(DATA_W-IdW){1'b0}}, byte_w};
    end else begin : g_narrow
      assign code_o = byte_w[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 16,
  parameter logic [6:0]  MFR_ID7 = 7'h01,
  parameter logic [6:0]  DEV_ID7 = 7'h19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              a9_hv_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  mode_e             mode;
  logic              drive;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] id_code;

  eprom_mode_dec i_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_hi_i (vpp_hi_i),
    .a9_hv_i  (a9_hv_i),
    .mode_o   (mode),
    .drive_o  (drive)
  );

  eprom_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .ce_ni     (ce_ni),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .erase_i   (erase_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (addr_i),
    .rd_data_o (rd_data)
  );

  eprom_ident #(.DATA_W(DATA_W), .MFR_ID7(MFR_ID7), .DEV_ID7(DEV_ID7)) i_ident (
    .sel_dev_i (addr_i[0]),
    .code_o    (id_code)
  );

  always_comb begin
    if (!drive)               data_o = '0;
    else if (mode == MD_IDENT) data_o = id_code;
    else                      data_o = rd_data;
  end
  assign data_oe_o = drive;

  assert_standby_hiz_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !vpp_hi_i) |-> !data_oe_o);

  assert_prog_hiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_PROG) |-> !data_oe_o);

  assert_ident_parity_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && a9_hv_i) |->
      (data_oe_o && (^data_o[7:0]) && (data_o[DATA_W-1:8] == '0)));

  assert_inhibit_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MD_INHIBIT) && ($past(mode) == MD_INHIBIT)) |-> (!wr_en && !data_oe_o));
endmodule

// File: tb/test_eprom_mode_model.sv
module test_eprom_mode_model;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 0;
  logic          rst_ni = 0;
  logic          ce = 1, oe = 1, vpp = 0, a9 = 0, erase = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '1;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  logic [DW-1:0] exp_mem [NW];
  int            n_run = 0, n_fail = 0, cyc = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  eprom_mode_model i_eprom_mode_model (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce), .oe_ni(oe), .vpp_hi_i(vpp),
    .a9_hv_i(a9), .erase_i(erase), .addr_i(addr), .data_i(din),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input logic [DW-1:0] salt);
    return DW'(a * 40503 + 7) ^ salt;
  endfunction

  task automatic idle();
    @(negedge clk);
    ce = 1; oe = 1; vpp = 0; a9 = 0; erase = 0; din = '1;
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk);
    ce = 0; oe = 0; vpp = 0; a9 = 0; addr = AW'(a);
    #1 chk(data_oe_o && data_o == exp_mem[a], req, {data_oe_o, data_o}, {1'b1, exp_mem[a]});
  endtask

  task automatic prog_word(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] old;
    old = exp_mem[a];
    @(negedge clk);
    ce = 0; oe = 1; vpp = 1; a9 = 0; addr = AW'(a); din = d;
    @(negedge clk);
    ce = 1; oe = 0;
    #1 chk(data_oe_o && data_o == old, "R6 verify before commit", data_o, old);
    @(negedge clk);
    #1 chk(data_oe_o && data_o == (old & d), "R4 R9 commit", data_o, old & d);
    exp_mem[a] = old & d;
    oe = 1; vpp = 0; din = '1;
  endtask

  task automatic do_erase();
    @(negedge clk); erase = 1;
    @(negedge clk); erase = 0;
    for (int i = 0; i < NW; i++) exp_mem[i] = '1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!data_oe_o, "R3 reset state", data_oe_o, 0);
    rst_ni = 1;

    do_erase();
    for (int i = 0; i < NW; i++) rd_chk(i, "R10 erased word");

    for (int i = 0; i < NW; i++) prog_word(i, pat(i, 16'h5A5A));
    idle();
    for (int i = 0; i < NW; i++) rd_chk(i, "R1 read after pass 1");

    // full control sweep; din all ones keeps any commit harmless
    for (int k = 0; k < 32; k++) begin
      logic c, o, v, h, z, e_oe;
      logic [DW-1:0] e_d;
      c = k[0]; o = k[1]; v = k[2]; h = k[3]; z = k[4];
      @(negedge clk);
      ce = c; oe = o; vpp = v; a9 = h; addr = AW'(z); din = '1;
      e_oe = (!c && !o) || (c && v && !o);
      if (!c && !o && h) e_d = z ? 16'h0019 : 16'h0001;
      else               e_d = exp_mem[z];
      #1;
      if (!c && !o && h)
        chk(data_oe_o && data_o == e_d, "R8 identifier", data_o, e_d);
      else if (!c && !o)
        chk(data_oe_o && data_o == e_d, "R1 read sweep", data_o, e_d);
      else if (c && v && !o)
        chk(data_oe_o && data_o == e_d, "R6 verify sweep", data_o, e_d);
      else if (c && v)
        chk(!data_oe_o, "R7 inhibit hiz", data_oe_o, 0);
      else if (c)
        chk(!data_oe_o, "R3 standby hiz", data_oe_o, 0);
      else if (v)
        chk(!data_oe_o, "R4 program hiz", data_oe_o, 0);
      else
        chk(!data_oe_o, "R2 output off", data_oe_o, 0);
      idle();
    end

    for (int i = 0; i < NW; i++) prog_word(i, pat(i * 3, 16'hC3F0));
    idle();
    for (int i = 0; i < NW; i++) rd_chk(i, "R9 read after pass 2");

    // R5: pulse ended by output enable with strobe low
    @(negedge clk); ce = 0; oe = 1; vpp = 1; addr = 10'd6; din = 16'h0000;
    @(negedge clk); oe = 0; vpp = 0;
    @(negedge clk); ce = 1; oe = 1;
    idle();
    rd_chk(6, "R5 no commit without strobe rise");

    // R5: pulse cut by reset
    @(negedge clk); ce = 0; oe = 1; vpp = 1; addr = 10'd5; din = 16'h0000;
    @(negedge clk); rst_ni = 0; ce = 1; vpp = 0;
    @(negedge clk); rst_ni = 1;
    idle();
    rd_chk(5, "R5 no commit after reset");

    // R7: inhibit held with zero data
    @(negedge clk); ce = 1; oe = 1; vpp = 1; addr = 10'd7; din = 16'h0000;
    repeat (3) begin
      @(negedge clk);
      #1 chk(!data_oe_o, "R7 inhibit output", data_oe_o, 0);
    end
    idle();
    rd_chk(7, "R7 inhibit leaves word");

    // R10: erase wins over a commit at the same edge
    @(negedge clk); ce = 0; oe = 1; vpp = 1; addr = 10'd8; din = 16'h0000;
    @(negedge clk); ce = 1; erase = 1;
    @(negedge clk); erase = 0; vpp = 0;
    for (int i = 0; i < NW; i++) exp_mem[i] = '1;
    for (int i = 0; i < NW; i++) rd_chk(i, "R10 erase over commit");

    idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule